// File: doc/BRIEF.md
# Pipelined Three-Tap FIR Filter

This block is a direct-form finite impulse response filter with three taps. It accepts one signed sample per clock and produces one filtered sample per clock. The output is the weighted sum of the newest accepted sample and the two accepted before it. Each weight is its own coefficient input, and the coefficients are held constant while samples flow. The filter is meant for a datapath whose clock period equals the sample period.

The output register alone would leave one multiply and two additions between registers. To shorten that path, one rank of registers is placed across a feed-forward cut. The first stage forms the products and adds the two newest weighted taps. It carries the oldest weighted tap forward on its own. The second stage then performs the last addition. The transfer function is unchanged, and the result leaves one clock later than it would from an unpipelined form.

A sample strobe marks the cycles that carry data. Cycles without the strobe neither advance the delay line nor produce an output. An output strobe travels with each result. Arithmetic keeps full precision throughout, so no input combination can overflow.

Top module: `fir3_pipe`

## Requirements
- R1: For accepted samples x[n], x[n-1], x[n-2] (newest first) and coefficients `coef0`, `coef1`, `coef2`, `out_sample` equals coef0*x[n] + coef1*x[n-1] + coef2*x[n-2]. All values are two's complement. The output is the exact 34-bit signed result, including when every operand is -32768 or 32767.
- R2: A cycle with `in_valid` low does not shift the delay line, and the value on `in_sample` in that cycle has no effect on any later output.
- R3: `out_valid` is high in the cycle after the third rising edge that follows an edge where `in_valid` was sampled high. This is one edge more than an unpipelined form needs. `out_valid` is low after an edge where no accepted sample has reached the output.
- R4: While `out_valid` is low, `out_sample` keeps the last result it presented (zero if none since reset).
- R5: A synchronous active-high `rst` clears the delay line, both pipeline stages and the strobe pipeline. After reset, `out_valid` and `out_sample` are 0, and the first results after reset treat the older taps as zero.
- R6: N accepted samples on consecutive clocks produce N results on consecutive clocks. One result leaves per clock, with no stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one sample period per cycle |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | High when `in_sample` carries a sample to accept |
| in_sample | input | 16 | Signed input sample |
| coef0 | input | 16 | Signed weight of the newest sample |
| coef1 | input | 16 | Signed weight of the previous sample |
| coef2 | input | 16 | Signed weight of the oldest sample |
| out_valid | output | 1 | High when `out_sample` presents a new result |
| out_sample | output | 34 | Signed full-precision filter result |

## Verification
The hardest case to produce from the ports is a result whose three taps were accepted across gaps. In that case the delay line has held its contents through invalid cycles while junk values sat on the sample input. The stimulus table therefore mixes accepted samples with invalid cycles that carry large, nonzero values. Any junk value that leaked into the delay line would change the next sum. A reset is also issued while the pipeline is full. A lone sample follows it, and its result must show that both older taps were cleared.

// File: rtl/fir3_pkg.sv
package fir3_pkg;

    localparam int NTAPS      = 3;
    localparam int DEF_DATA_W = 16;
    localparam int DEF_COEF_W = 16;

    // Growth bits needed to add NTAPS full-width products.
    function automatic int growth_bits(input int taps);
        int g;
        g = 0;
        while ((1 << g) < taps) g++;
        return g;
    endfunction

    function automatic int acc_width(input int dw, input int cw, input int taps);
        return dw + cw + growth_bits(taps);
    endfunction

endpackage

// File: rtl/fir3_tapline.sv
module fir3_tapline #(
    parameter int DATA_W = 16,
    parameter int NTAPS  = 3
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    input  logic [DATA_W-1:0]       in_sample,
    output logic [NTAPS*DATA_W-1:0] taps,
    output logic                    tap_valid
);

    typedef struct packed {
        logic [NTAPS-1:0][DATA_W-1:0] x;
        logic                         v;
    } tap_state_t;

    tap_state_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        st_d.v = in_valid;
        if (in_valid) begin
            st_d.x[0] = in_sample;
            for (int i = 1; i < NTAPS; i++) begin
                st_d.x[i] = st_q.x[i-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    generate
        for (genvar g = 0; g < NTAPS; g++) begin : g_out
            assign taps[g*DATA_W +: DATA_W] = st_q.x[g];
        end
    endgenerate

    assign tap_valid = st_q.v;

endmodule

// File: rtl/fir3_stage1.sv
module fir3_stage1 #(
    parameter int DATA_W = 16,
    parameter int COEF_W = 16,
    parameter int NTAPS  = 3,
    parameter int ACC_W  = DATA_W + COEF_W + 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [NTAPS*DATA_W-1:0] taps,
    input  logic                    tap_valid,
    input  logic [NTAPS*COEF_W-1:0] coefs,
    output logic [ACC_W-1:0]        head_sum,
    output logic [ACC_W-1:0]        tail_prod,
    output logic                    s1_valid
);

    localparam int PROD_W = DATA_W + COEF_W;
    localparam int EXT_W  = ACC_W - PROD_W;

    typedef struct packed {
        logic [ACC_W-1:0] head;
        logic [ACC_W-1:0] tail;
        logic             v;
    } s1_state_t;

    s1_state_t        st_d, st_q;
    logic [PROD_W-1:0] prod [NTAPS];
    logic [ACC_W-1:0]  head_acc;

    generate
        for (genvar g = 0; g < NTAPS; g++) begin : g_mul
            assign prod[g] = $signed(taps[g*DATA_W +: DATA_W]) *
                             $signed(coefs[g*COEF_W +: COEF_W]);
        end
    endgenerate

    // Newest NTAPS-1 weighted taps share one adder chain; oldest rides alone.
    always_comb begin
        head_acc = '0;
        for (int i = 0; i < NTAPS - 1; i++) begin
            head_acc = head_acc + {{EXT_W{prod[i][PROD_W-1]}}, prod[i]};
        end
    end

    always_comb begin
        st_d   = st_q;
        st_d.v = tap_valid;
        if (tap_valid) begin
            st_d.head = head_acc;
            st_d.tail = {{EXT_W{prod[NTAPS-1][PROD_W-1]}}, prod[NTAPS-1]};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign head_sum  = st_q.head;
    assign tail_prod = st_q.tail;
    assign s1_valid  = st_q.v;

endmodule

// File: rtl/fir3_stage2.sv
module fir3_stage2 #(
    parameter int ACC_W = 34
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [ACC_W-1:0] head_sum,
    input  logic [ACC_W-1:0] tail_prod,
    input  logic             s1_valid,
    output logic [ACC_W-1:0] result,
    output logic             result_valid
);

    typedef struct packed {
        logic [ACC_W-1:0] y;
        logic             v;
    } s2_state_t;

    s2_state_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        st_d.v = s1_valid;
        if (s1_valid) begin
            st_d.y = head_sum + tail_prod;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign result       = st_q.y;
    assign result_valid = st_q.v;

endmodule

// File: rtl/fir3_pipe.sv
module fir3_pipe
    import fir3_pkg::*;
#(
    parameter int DATA_W = DEF_DATA_W,
    parameter int COEF_W = DEF_COEF_W
) (
    input  logic                                       clk,
    input  logic                                       rst,
    input  logic                                       in_valid,
    input  logic [DATA_W-1:0]                          in_sample,
    input  logic [COEF_W-1:0]                          coef0,
    input  logic [COEF_W-1:0]                          coef1,
    input  logic [COEF_W-1:0]                          coef2,
    output logic                                       out_valid,
    output logic [acc_width(DATA_W, COEF_W, NTAPS)-1:0] out_sample
);

    localparam int ACC_W = acc_width(DATA_W, COEF_W, NTAPS);

    logic [NTAPS*DATA_W-1:0] tap_bus;
    logic                    tap_vld;
    logic [NTAPS*COEF_W-1:0] coef_bus;
    logic [ACC_W-1:0]        head_q;
    logic [ACC_W-1:0]        tail_q;
    logic                    s1_vld;

    assign coef_bus = {coef2, coef1, coef0};

    fir3_tapline #(
        .DATA_W (DATA_W),
        .NTAPS  (NTAPS)
    ) u_tapline (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_sample (in_sample),
        .taps      (tap_bus),
        .tap_valid (tap_vld)
    );

    fir3_stage1 #(
        .DATA_W (DATA_W),
        .COEF_W (COEF_W),
        .NTAPS  (NTAPS),
        .ACC_W  (ACC_W)
    ) u_stage1 (
        .clk       (clk),
        .rst       (rst),
        .taps      (tap_bus),
        .tap_valid (tap_vld),
        .coefs     (coef_bus),
        .head_sum  (head_q),
        .tail_prod (tail_q),
        .s1_valid  (s1_vld)
    );

    fir3_stage2 #(
        .ACC_W (ACC_W)
    ) u_stage2 (
        .clk          (clk),
        .rst          (rst),
        .head_sum     (head_q),
        .tail_prod    (tail_q),
        .s1_valid     (s1_vld),
        .result       (out_sample),
        .result_valid (out_valid)
    );

endmodule

// File: rtl/fir3_pipe_chk.sv
module fir3_pipe_chk #(
    parameter int DATA_W = 16,
    parameter int COEF_W = 16,
    parameter int NTAPS  = 3,
    parameter int ACC_W  = 34
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    in_valid,
    input logic [COEF_W-1:0]       coef0,
    input logic [COEF_W-1:0]       coef1,
    input logic [COEF_W-1:0]       coef2,
    input logic [NTAPS*DATA_W-1:0] taps,
    input logic                    out_valid,
    input logic [ACC_W-1:0]        out_sample
);

    logic signed [ACC_W-1:0] ref_sum;

    // End-to-end reference from the delay-line contents, two edges upstream.
    always_comb begin
        ref_sum = $signed(taps[0 +: DATA_W])          * $signed(coef0)
                + $signed(taps[DATA_W +: DATA_W])     * $signed(coef1)
                + $signed(taps[2*DATA_W +: DATA_W])   * $signed(coef2);
    end

    // R1
    filter_sum_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ($signed(out_sample) == $past(ref_sum, 2)));

    // R2
    tap_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(taps));

    // R3
    valid_latency_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> ##2 out_valid);

    // R3
    no_spurious_valid_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ##2 !out_valid);

    // R4
    output_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!out_valid && !$past(rst)) |-> $stable(out_sample));

    // R5
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!out_valid && out_sample == '0 && taps == '0));

endmodule

bind fir3_pipe fir3_pipe_chk #(
    .DATA_W (DATA_W),
    .COEF_W (COEF_W),
    .NTAPS  (fir3_pkg::NTAPS),
    .ACC_W  (ACC_W)
) u_fir3_pipe_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .coef0      (coef0),
    .coef1      (coef1),
    .coef2      (coef2),
    .taps       (tap_bus),
    .out_valid  (out_valid),
    .out_sample (out_sample)
);

// File: tb/test_fir3_pipe.sv
module test_fir3_pipe;

    localparam int DW = 16;
    localparam int CW = 16;
    localparam int OW = 34;
    localparam int DEPTH = 1024;
    localparam int NSTIM = 24;

    // Stimulus: {valid, sample}. Invalid rows carry junk that must be ignored.
    localparam logic [DW:0] STIM [NSTIM] = '{
        {1'b1, 16'sd10},   {1'b1, 16'sd20},   {1'b1, -16'sd30},  {1'b0, 16'h5A5A},
        {1'b1, 16'sd40},   {1'b0, 16'h7FFF},  {1'b0, 16'h8000},  {1'b1, -16'sd1},
        {1'b1, 16'h7FFF},  {1'b1, 16'h8000},  {1'b1, 16'h7FFF},  {1'b0, 16'h1234},
        {1'b1, 16'sd0},    {1'b1, 16'sd0},    {1'b1, 16'sd100},  {1'b0, -16'sd77},
        {1'b0, 16'sd3},    {1'b0, 16'hFFFF},  {1'b1, -16'sd500}, {1'b1, 16'sd250},
        {1'b0, 16'h4444},  {1'b1, 16'sd7},    {1'b1, -16'sd7},   {1'b1, 16'sd1}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic [DW-1:0] in_sample = '0;
    logic [CW-1:0] coef0 = '0;
    logic [CW-1:0] coef1 = '0;
    logic [CW-1:0] coef2 = '0;
    logic          out_valid;
    logic [OW-1:0] out_sample;

    always #4 clk = ~clk;

    fir3_pipe #(.DATA_W(DW), .COEF_W(CW)) i_fir3_pipe (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_sample  (in_sample),
        .coef0      (coef0),
        .coef1      (coef1),
        .coef2      (coef2),
        .out_valid  (out_valid),
        .out_sample (out_sample)
    );

    int     checks = 0;
    int     errors = 0;
    int     cyc = 0;
    bit     exp_v [DEPTH];
    longint exp_y [DEPTH];
    longint hold_y = 0;
    longint h0 = 0, h1 = 0, h2 = 0;
    longint c0 = 0, c1 = 0, c2 = 0;
    int     run_len = 0;
    int     max_run = 0;

    function automatic longint out_val();
        return longint'($signed(out_sample));
    endfunction

    task automatic check(input string req, input bit ok, input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, expv, $time);
        end
    endtask

    task automatic cycle_check();
        if (exp_v[cyc]) hold_y = exp_y[cyc];
        // R3: strobe appears exactly three edges after acceptance
        check("R3", out_valid == exp_v[cyc], longint'(out_valid), longint'(exp_v[cyc]));
        if (exp_v[cyc]) begin
            // R1/R2: value is the convolution of accepted samples only
            check("R1/R2", out_val() == hold_y, out_val(), hold_y);
        end else begin
            // R4: held value while strobe is low
            check("R4", out_val() == hold_y, out_val(), hold_y);
        end
        if (out_valid) begin
            run_len++;
            if (run_len > max_run) max_run = run_len;
        end else begin
            run_len = 0;
        end
    endtask

    task automatic step(input bit v, input logic [DW-1:0] s);
        @(negedge clk);
        cycle_check();
        if (v) begin
            h2 = h1;
            h1 = h0;
            h0 = longint'($signed(s));
            exp_v[cyc+3] = 1'b1;
            exp_y[cyc+3] = c0*h0 + c1*h1 + c2*h2;
        end
        in_valid  = v;
        in_sample = s;
        cyc++;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) step(1'b0, 16'h3C3C);
    endtask

    task automatic set_coefs(input logic [CW-1:0] a, input logic [CW-1:0] b, input logic [CW-1:0] c);
        idle(4);
        coef0 = a; coef1 = b; coef2 = c;
        c0 = longint'($signed(a));
        c1 = longint'($signed(b));
        c2 = longint'($signed(c));
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        in_valid = 1'b0;
        in_sample = 16'hBEEF;
        repeat (2) @(negedge clk);
        // R5: cleared state at the ports
        check("R5", out_valid == 1'b0, longint'(out_valid), 0);
        check("R5", out_sample == '0, out_val(), 0);
        rst = 1'b0;
        h0 = 0; h1 = 0; h2 = 0;
        hold_y = 0;
        run_len = 0;
        cyc = 0;
        for (int k = 0; k < DEPTH; k++) exp_v[k] = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        do_reset();

        // Table walk: mixed valid/junk cycles, extremes included (R1, R2, R3, R4)
        set_coefs(16'sd3, -16'sd5, 16'sd7);
        for (int i = 0; i < NSTIM; i++) begin
            step(STIM[i][DW], STIM[i][DW-1:0]);
        end
        idle(6);

        // Impulse: response reproduces the weights in order (R1)
        set_coefs(16'sd1000, -16'sd2000, 16'sd3000);
        step(1'b1, 16'sd1);
        step(1'b1, 16'sd0);
        step(1'b1, 16'sd0);
        step(1'b1, 16'sd0);
        idle(5);

        // Extremes: largest magnitudes without overflow (R1)
        set_coefs(16'h8000, 16'h8000, 16'h8000);
        for (int i = 0; i < 3; i++) step(1'b1, 16'h8000);
        idle(3);
        check("R1", out_val() == 64'sd3221225472, out_val(), 64'sd3221225472);
        for (int i = 0; i < 3; i++) step(1'b1, 16'h7FFF);
        idle(3);
        check("R1", out_val() == -64'sd3221127168, out_val(), -64'sd3221127168);

        // Back-to-back stream: one result per clock (R6)
        set_coefs(16'sd2, 16'sd1, -16'sd1);
        max_run = 0;
        run_len = 0;
        for (int i = 0; i < 8; i++) step(1'b1, DW'(i * 11 - 20));
        idle(5);
        check("R6", max_run == 8, longint'(max_run), 8);

        // Reset with a full pipeline, then a lone sample (R5)
        set_coefs(16'sd2, 16'sd3, 16'sd4);
        for (int i = 0; i < 3; i++) step(1'b1, 16'sd900);
        do_reset();
        step(1'b1, 16'sd5);
        idle(4);
        check("R5", out_val() == 10, out_val(), 10);
        step(1'b1, 16'sd1);
        idle(4);
        check("R5", out_val() == 17, out_val(), 17);

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule